// File: doc/BRIEF.md
# Paged flash read front-end

This block is a clocked model of the read side of a parallel NOR-style flash. A page buffer holds the words around the requested address. Loading that buffer from the backing array costs a long access delay. After the load, any word or byte inside the page comes out after a short delay, in any order and as often as wanted. A new upper address or a pulse low on chip enable makes the block sense the array again. The backing array is an internal constant memory that is computed from its index, so any read can be predicted.

Bus writes drive a small command decoder. One write selects register reads. In that mode a single word, the configuration register, is loaded instead of a page. Another write returns the block to array reads. A pair of writes stores a new configuration register value, which both writes carry on `addr[15:0]`. Bit 0 of that register sets the page size to 4 or 8 words. The output is 16 bits wide (x16), or one byte at a time on the low 8 bits (x8).

Top module: `pflash_rd_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rvalid` and `rdata` are 0. The configuration register reads 0, which selects 4-word pages. The command decoder is in array-read mode. A later pulse low on `rst_n` restores these values.
- R2: With 4-word pages and `byte_mode`=0, word index `addr[2:1]` selects the word within the page. `rdata` is the array word at `addr>>1`. `addr[0]` has no effect on the output.
- R3: With `byte_mode`=1, `rdata[7:0]` is the low byte of the addressed word when `addr[0]`=0 and the high byte when `addr[0]`=1. `rdata[15:8]` is 0. With 4-word pages, the byte offset within the page is `addr[2:0]`.
- R4: With 8-word pages, the word index is `addr[3:1]` and the byte offset is `addr[3:0]`. The page changes only when `addr[15:4]` changes, so a change of `addr[3]` stays within the page.
- R5: After a page miss, `rvalid` goes high exactly `T_INIT` clock edges after the first edge that samples the read. The data is the word or byte at the starting address.
- R6: Once a page is loaded, a change of the in-page offset or of `byte_mode` drops `rvalid` at once. `rvalid` is high again exactly `T_PAGE` edges later. Offsets may be read in any order and repeated, and this costs no new sense.
- R7: A change of the address bits above the page offset forces a new sense with `T_INIT` latency. With 4-word pages this applies to `addr[3]` and up.
- R8: `chip_en` low for one edge or more invalidates the page. A read of the same address afterwards takes `T_INIT`.
- R9: `rvalid` is high only while `chip_en`=1, `out_en`=1 and `wr_en`=0. `rdata` is 0 whenever `rvalid` is 0. Any write invalidates the page.
- R10: The write 0x60 followed by the write 0x04 loads `addr[15:0]` of the second write into the configuration register. The block then returns to array reads.
- R11: If the second write is not 0x04, the configuration register keeps its value and the block returns to array reads.
- R12: The write 0x90 selects register reads and the write 0xFF selects array reads. In register mode, every offset returns the configuration register as one word, with the normal `T_INIT` and `T_PAGE` timing and the normal x8 byte selection.
- R13: Only bit 0 of the configuration register sets the page size. The other 15 bits are stored, read back through register mode, and have no effect on paging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Device select, active high |
| out_en | input | 1 | Output enable, active high |
| wr_en | input | 1 | Write strobe; each edge with `chip_en` and `wr_en` high is one write |
| byte_mode | input | 1 | 1 selects x8 output, 0 selects x16 output |
| addr | input | ADDR_W | Byte address; bit 0 selects the byte in x8 |
| wdata | input | 8 | Command code for writes |
| rdata | output | 16 | Read data, 0 when not valid |
| rvalid | output | 1 | Qualifies `rdata` |

## Verification
The bench sweeps every offset of pages at low, middle and top addresses. It covers both page sizes and both bus widths, and visits the offsets in a permuted order that ends on a repeat. Each step also checks the cycle before the data appears. This separates the long sense latency from the short in-page latency, and shows that a repeat costs no new sense. Toggling `addr[3]` under each page size shows where the page boundary lies. The bench runs the configuration sequence three ways: with a good confirm, with a bad confirm, and with a value whose bit 0 is clear but other bits are set. Register-mode reads then show which value was stored and which page size took effect.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY    = 2'd0,
    MODE_CFG_WAIT = 2'd1,
    MODE_REG      = 2'd2
  } cmd_mode_e;

  // Constant content of the backing array: an odd multiplier keeps words distinct
  function automatic logic [15:0] cell_value(input int unsigned idx);
    logic [31:0] prod;
    prod = idx * 32'd291 + 32'd7994;
    return prod[15:0];
  endfunction

  // Word index inside the page for the selected page size
  function automatic logic [2:0] page_index(input logic page8, input logic [2:0] low);
    return page8 ? low : {1'b0, low[1:0]};
  endfunction

  // Byte-mode output: pick one half of the word, zero-extend
  function automatic logic [15:0] lane_pick(input logic [15:0] word, input logic bsel,
                                            input logic byte_mode);
    if (!byte_mode) return word;
    return bsel ? {8'h00, word[15:8]} : {8'h00, word[7:0]};
  endfunction

endpackage

// File: rtl/pflash_array.sv
module pflash_array #(
  parameter int WADDR_W  = 15,
  parameter int MEM_LOG2 = 7,
  parameter int PAGE_MAX = 8
) (
  input  logic [WADDR_W-1:0]             page_base,
  output logic [PAGE_MAX-1:0][15:0]      page_words
);
  localparam int DEPTH = 1 << MEM_LOG2;

  logic [15:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign mem[g] = pflash_pkg::cell_value(g);
  end

  for (genvar i = 0; i < PAGE_MAX; i++) begin : g_port
    logic [MEM_LOG2-1:0] idx;
    assign idx = page_base[MEM_LOG2-1:0] + MEM_LOG2'(i);
    assign page_words[i] = mem[idx];
  end
endmodule

// File: rtl/pflash_cmd.sv
module pflash_cmd #(
  parameter logic [7:0] CMD_READ_ARRAY  = 8'hFF,
  parameter logic [7:0] CMD_SET_CFG     = 8'h60,
  parameter logic [7:0] CMD_CFG_CONFIRM = 8'h04,
  parameter logic [7:0] CMD_READ_REG    = 8'h90
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_evt,
  input  logic [7:0]             wdata,
  input  logic [15:0]            addr_lo,
  output logic [15:0]            cfg_q,
  output pflash_pkg::cmd_mode_e  cmd_mode
);
  import pflash_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_mode <= MODE_ARRAY;
      cfg_q    <= 16'h0000;
    end else if (wr_evt) begin
      if (cmd_mode == MODE_CFG_WAIT) begin
        cmd_mode <= MODE_ARRAY;
        if (wdata == CMD_CFG_CONFIRM) cfg_q <= addr_lo;
      end else begin
        case (wdata)
          CMD_SET_CFG:    cmd_mode <= MODE_CFG_WAIT;
          CMD_READ_REG:   cmd_mode <= MODE_REG;
          CMD_READ_ARRAY: cmd_mode <= MODE_ARRAY;
          default:        cmd_mode <= cmd_mode;
        endcase
      end
    end
  end
endmodule

// File: rtl/pflash_page.sv
module pflash_page #(
  parameter int ADDR_W   = 16,
  parameter int PAGE_MAX = 8,
  parameter int T_INIT   = 6,
  parameter int T_PAGE   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         chip_en,
  input  logic                         rd_act,
  input  logic                         wr_evt,
  input  logic                         page8,
  input  logic                         reg_mode,
  input  logic                         byte_mode,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [PAGE_MAX-1:0][15:0]    arr_words,
  input  logic [15:0]                  reg_word,
  output logic [ADDR_W-2:0]            page_base,
  output logic                         rvalid,
  output logic [15:0]                  rdata,
  output logic                         page_hit,
  output logic                         sense_start,
  output logic                         page_load
);
  import pflash_pkg::*;

  localparam int WADDR_W = ADDR_W - 1;
  localparam int T_MAX   = (T_INIT > T_PAGE) ? T_INIT : T_PAGE;
  localparam int CNT_W   = $clog2(T_MAX + 1);

  logic [WADDR_W-1:0]              waddr, tag, buf_tag, sense_tag;
  logic [2:0]                      idx, rsel;
  logic [4:0]                      off, off_q;
  logic                            buf_ok, busy, ready, same_off, miss;
  logic [CNT_W-1:0]                cnt;
  logic [PAGE_MAX-1:0][15:0]       pbuf;

  assign waddr    = addr[ADDR_W-1:1];
  assign tag      = page8 ? {waddr[WADDR_W-1:3], 3'b000} : {waddr[WADDR_W-1:2], 2'b00};
  assign idx      = page_index(page8, waddr[2:0]);
  assign rsel     = reg_mode ? 3'd0 : idx;
  assign off      = {byte_mode, byte_mode & addr[0], idx};

  assign page_hit = buf_ok && (tag == buf_tag);
  assign miss     = !page_hit;
  assign same_off = (off == off_q);

  assign sense_start = rd_act && miss && (!busy || (tag != sense_tag));
  assign page_load   = rd_act && miss && busy && (tag == sense_tag) && (cnt == '0);
  assign page_base   = sense_tag;

  assign rvalid = rd_act && page_hit && ready && same_off;
  assign rdata  = rvalid ? lane_pick(pbuf[rsel], addr[0], byte_mode) : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_ok    <= 1'b0;
      busy      <= 1'b0;
      ready     <= 1'b0;
      cnt       <= '0;
      off_q     <= '0;
      buf_tag   <= '0;
      sense_tag <= '0;
      pbuf      <= '0;
    end else if (!chip_en || wr_evt) begin
      buf_ok <= 1'b0;
      busy   <= 1'b0;
      ready  <= 1'b0;
    end else if (rd_act) begin
      if (sense_start) begin
        busy      <= 1'b1;
        buf_ok    <= 1'b0;
        ready     <= 1'b0;
        sense_tag <= tag;
        cnt       <= CNT_W'(T_INIT - 2);
      end else if (page_load) begin
        busy    <= 1'b0;
        buf_ok  <= 1'b1;
        buf_tag <= sense_tag;
        ready   <= 1'b1;
        off_q   <= off;
        for (int i = 0; i < PAGE_MAX; i++) begin
          if (reg_mode) pbuf[i] <= (i == 0) ? reg_word : 16'h0000;
          else          pbuf[i] <= arr_words[i];
        end
      end else if (miss) begin
        cnt <= cnt - CNT_W'(1);
      end else if (!same_off) begin
        off_q <= off;
        ready <= 1'b0;
        cnt   <= CNT_W'(T_PAGE - 2);
      end else if (!ready) begin
        if (cnt == '0) ready <= 1'b1;
        else           cnt   <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pflash_rd_top.sv
module pflash_rd_top #(
  parameter int         ADDR_W          = 16,
  parameter int         MEM_LOG2        = 7,
  parameter int         T_INIT          = 6,
  parameter int         T_PAGE          = 2,
  parameter int         CFG_PAGE_BIT    = 0,
  parameter logic [7:0] CMD_READ_ARRAY  = 8'hFF,
  parameter logic [7:0] CMD_SET_CFG     = 8'h60,
  parameter logic [7:0] CMD_CFG_CONFIRM = 8'h04,
  parameter logic [7:0] CMD_READ_REG    = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              out_en,
  input  logic              wr_en,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [15:0]       rdata,
  output logic              rvalid
);
  localparam int WADDR_W  = ADDR_W - 1;
  localparam int PAGE_MAX = 8;

  logic                        rd_act, wr_evt, page8, reg_mode;
  logic                        page_hit, sense_start, page_load;
  logic [15:0]                 cfg_q;
  pflash_pkg::cmd_mode_e       cmd_mode;
  logic [WADDR_W-1:0]          page_base;
  logic [PAGE_MAX-1:0][15:0]   arr_words;

  assign rd_act   = rst_n && chip_en && out_en && !wr_en;
  assign wr_evt   = chip_en && wr_en;
  assign page8    = cfg_q[CFG_PAGE_BIT];
  assign reg_mode = (cmd_mode == pflash_pkg::MODE_REG);

  pflash_cmd #(
    .CMD_READ_ARRAY (CMD_READ_ARRAY),
    .CMD_SET_CFG    (CMD_SET_CFG),
    .CMD_CFG_CONFIRM(CMD_CFG_CONFIRM),
    .CMD_READ_REG   (CMD_READ_REG)
  ) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_evt  (wr_evt),
    .wdata   (wdata),
    .addr_lo (addr[15:0]),
    .cfg_q   (cfg_q),
    .cmd_mode(cmd_mode)
  );

  pflash_array #(
    .WADDR_W (WADDR_W),
    .MEM_LOG2(MEM_LOG2),
    .PAGE_MAX(PAGE_MAX)
  ) u_array (
    .page_base (page_base),
    .page_words(arr_words)
  );

  pflash_page #(
    .ADDR_W  (ADDR_W),
    .PAGE_MAX(PAGE_MAX),
    .T_INIT  (T_INIT),
    .T_PAGE  (T_PAGE)
  ) u_page (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .rd_act     (rd_act),
    .wr_evt     (wr_evt),
    .page8      (page8),
    .reg_mode   (reg_mode),
    .byte_mode  (byte_mode),
    .addr       (addr),
    .arr_words  (arr_words),
    .reg_word   (cfg_q),
    .page_base  (page_base),
    .rvalid     (rvalid),
    .rdata      (rdata),
    .page_hit   (page_hit),
    .sense_start(sense_start),
    .page_load  (page_load)
  );
endmodule

// File: rtl/pflash_chk.sv
module pflash_chk #(
  parameter int         ADDR_W          = 16,
  parameter logic [7:0] CMD_CFG_CONFIRM = 8'h04
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   chip_en,
  input logic                   out_en,
  input logic                   wr_en,
  input logic                   byte_mode,
  input logic [ADDR_W-1:0]      addr,
  input logic [7:0]             wdata,
  input logic [15:0]            rdata,
  input logic                   rvalid,
  input logic [15:0]            cfg_q,
  input pflash_pkg::cmd_mode_e  cmd_mode,
  input logic                   wr_evt,
  input logic                   rd_act,
  input logic                   page_load
);
  import pflash_pkg::*;

  assert_reset_cfg_R1: assert property (@(posedge clk) !rst_n |=> (cfg_q == 16'h0000));

  assert_load_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    page_load |=> (!($stable(addr) && $stable(byte_mode) && rd_act) || rvalid));

  assert_hold_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(rvalid) && $stable(addr) && $stable(byte_mode)) |-> $stable(rdata));

  assert_ce_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !$past(chip_en)) |-> !rvalid);

  assert_out_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (chip_en && out_en && !wr_en));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == 16'h0000));

  assert_cfg_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode == MODE_CFG_WAIT && wr_evt && wdata == CMD_CFG_CONFIRM)
      |=> (cfg_q == $past(addr[15:0]) && cmd_mode == MODE_ARRAY));

  assert_bad_confirm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode == MODE_CFG_WAIT && wr_evt && wdata != CMD_CFG_CONFIRM)
      |=> ($stable(cfg_q) && cmd_mode == MODE_ARRAY));
endmodule

bind pflash_rd_top pflash_chk #(
  .ADDR_W         (ADDR_W),
  .CMD_CFG_CONFIRM(CMD_CFG_CONFIRM)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chip_en  (chip_en),
  .out_en   (out_en),
  .wr_en    (wr_en),
  .byte_mode(byte_mode),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .rvalid   (rvalid),
  .cfg_q    (cfg_q),
  .cmd_mode (cmd_mode),
  .wr_evt   (wr_evt),
  .rd_act   (rd_act),
  .page_load(page_load)
);

// File: tb/test_pflash_rd_top.sv
module test_pflash_rd_top;
  localparam int TI = 6;
  localparam int TP = 2;

  logic        clk = 1'b0;
  logic        rst_n, chip_en, out_en, wr_en, byte_mode;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [15:0] rdata;
  logic        rvalid;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  pflash_rd_top #(.T_INIT(TI), .T_PAGE(TP)) i_pflash_rd_top (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en), .wr_en(wr_en),
    .byte_mode(byte_mode), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  // Array model: 128 words, word n holds n*291 + 7994 modulo 2^16
  function automatic logic [15:0] model_word(input logic [15:0] a);
    logic [15:0] n;
    n = {9'd0, a[7:1]};
    return n * 16'd291 + 16'd7994;
  endfunction

  function automatic logic [15:0] model_read(input logic [15:0] a, input logic bm);
    logic [15:0] w;
    w = model_word(a);
    if (!bm) return w;
    return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic check(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h (addr %h)", req, act, exp, addr);
    end
  endtask

  // Starts and ends at a falling edge; lat counts edges until data is due
  task automatic rd(input logic [15:0] a, input logic bm, input logic [15:0] exp,
                    input int lat, input string req);
    string treq;
    treq = (lat == TI) ? "R5" : "R6";
    addr = a;
    byte_mode = bm;
    if (lat == 0) begin
      #1;
      check(rvalid == 1'b1 && rdata == exp, req, rdata, exp);
    end else begin
      if (lat > 1) begin
        repeat (lat - 1) @(posedge clk);
        #1;
        check(rvalid == 1'b0, treq, {15'd0, rvalid}, 16'h0000);
      end
      @(posedge clk);
      #1;
      check(rvalid == 1'b1, treq, {15'd0, rvalid}, 16'h0001);
      check(rdata == exp, req, rdata, exp);
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] c, input logic [15:0] a);
    addr = a;
    wdata = c;
    out_en = 1'b0;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    out_en = 1'b1;
  endtask

  task automatic ce_toggle();
    chip_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chip_en = 1'b1;
  endtask

  // Visits every unit of a page in a permuted order, ending on a repeat
  task automatic sweep(input logic [15:0] base, input logic bm, input int units,
                       input int step, input int start, input string req);
    ce_toggle();
    for (int j = 0; j <= units; j++) begin
      int u;
      logic [15:0] a;
      u = (start + step * j) % units;
      a = bm ? base + 16'(u) : base + 16'(2 * u);
      rd(a, bm, model_read(a, bm), (j == 0) ? TI : TP, req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] b16 [5];
    rst_n = 1'b0; chip_en = 1'b0; out_en = 1'b0; wr_en = 1'b0;
    byte_mode = 1'b0; addr = 16'h0000; wdata = 8'h00;
    b16[0] = 16'h0000; b16[1] = 16'h0008; b16[2] = 16'h00F8;
    b16[3] = 16'h1230; b16[4] = 16'hFFF8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rvalid == 1'b0 && rdata == 16'h0000, "R1", rdata, 16'h0000);
    rst_n = 1'b1; chip_en = 1'b1; out_en = 1'b1;
    @(negedge clk);

    // R1: default configuration through a register read, then back to array
    wr(8'h90, 16'h0000);
    rd(16'h0000, 1'b0, 16'h0000, TI, "R1");
    wr(8'hFF, 16'h0000);

    // R2: x16, 4-word pages at several places in the address space
    foreach (b16[k]) sweep(b16[k], 1'b0, 4, 3, 2, "R2");
    rd(16'hFFFD, 1'b0, model_word(16'hFFFC), 0, "R2");

    // R3: x8, 4-word pages
    sweep(16'h0010, 1'b1, 8, 3, 5, "R3");
    sweep(16'h0A38, 1'b1, 8, 3, 5, "R3");

    // R7: addr[3] is above the offset with 4-word pages
    rd(16'h0040, 1'b0, model_word(16'h0040), TI, "R7");
    rd(16'h0048, 1'b0, model_word(16'h0048), TI, "R7");
    rd(16'h004A, 1'b0, model_word(16'h004A), TP, "R7");

    // R8: chip enable pulse forces a new sense of the same page
    ce_toggle();
    rd(16'h004A, 1'b0, model_word(16'h004A), TI, "R8");

    // R9: output gating
    out_en = 1'b0;
    #1 check(rvalid == 1'b0 && rdata == 16'h0000, "R9", rdata, 16'h0000);
    @(negedge clk);
    out_en = 1'b1;
    #1 check(rvalid == 1'b1 && rdata == model_word(16'h004A), "R9", rdata, model_word(16'h004A));
    @(negedge clk);
    wdata = 8'h00;
    wr_en = 1'b1;
    #1 check(rvalid == 1'b0 && rdata == 16'h0000, "R9", rdata, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd(16'h004A, 1'b0, model_word(16'h004A), TI, "R9");
    chip_en = 1'b0;
    #1 check(rvalid == 1'b0 && rdata == 16'h0000, "R9", rdata, 16'h0000);
    @(negedge clk);
    chip_en = 1'b1;

    // R10: select 8-word pages
    wr(8'h60, 16'h0001);
    wr(8'h04, 16'h0001);
    rd(16'h0040, 1'b0, model_word(16'h0040), TI, "R10");
    rd(16'h0048, 1'b0, model_word(16'h0048), TP, "R4");
    rd(16'h0050, 1'b0, model_word(16'h0050), TI, "R4");
    sweep(16'h0100, 1'b0, 8, 3, 5, "R4");
    sweep(16'h7FF0, 1'b0, 8, 3, 5, "R4");
    sweep(16'h0220, 1'b1, 16, 5, 11, "R4");

    // R12: register reads return the configuration word at any offset
    wr(8'h90, 16'h0000);
    rd(16'h0300, 1'b0, 16'h0001, TI, "R12");
    rd(16'h0306, 1'b0, 16'h0001, TP, "R12");
    rd(16'h0307, 1'b1, 16'h0000, TP, "R12");
    rd(16'h0306, 1'b1, 16'h0001, TP, "R12");

    // R11: bad confirm keeps the value and returns to array reads
    wr(8'h60, 16'h0000);
    wr(8'h33, 16'h0000);
    rd(16'h0040, 1'b0, model_word(16'h0040), TI, "R11");
    rd(16'h0048, 1'b0, model_word(16'h0048), TP, "R11");
    wr(8'h90, 16'h0000);
    rd(16'h0000, 1'b0, 16'h0001, TI, "R11");

    // R13: upper bits stored, only bit 0 decides the page size
    wr(8'h60, 16'hA5A4);
    wr(8'h04, 16'hA5A4);
    rd(16'h0040, 1'b0, model_word(16'h0040), TI, "R13");
    rd(16'h0048, 1'b0, model_word(16'h0048), TI, "R13");
    wr(8'h90, 16'h0000);
    rd(16'h0000, 1'b0, 16'hA5A4, TI, "R13");
    rd(16'h0001, 1'b1, 16'h00A5, TP, "R13");

    // R1: a later reset restores the default
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wr(8'h90, 16'h0000);
    rd(16'h0000, 1'b0, 16'h0000, TI, "R1");
    wr(8'hFF, 16'h0000);
    rd(16'h0040, 1'b0, model_word(16'h0040), TI, "R1");
    rd(16'h0048, 1'b0, model_word(16'h0048), TI, "R1");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule